// File: doc/BRIEF.md
# Serial line coder with whitening

This block sits in the bit-serial path of a radio modem. On the transmit side it takes one data bit per input strobe from the framing logic and hands the modulator a coded bit stream; on the receive side it takes the coded stream back from the demodulator and restores the original data bits. The transforms are set by configuration inputs:
- whitening with one of three shift-register polynomials, either additive (keystream) or multiplicative (self-synchronising);
- differential coding;
- Manchester coding;
- inversion, which in four-level mode can act on each bit of a dibit on its own.

The transmit order is whitening, differential coding, Manchester coding, then inversion. The receive path undoes them in the opposite order, and it flags Manchester half-bit pairs that cannot occur.

A packet-start pulse puts all coding state back to its start value. If that pulse comes in the same cycle as a strobe, the start value already applies to that bit. Whitening adds no bits, so without Manchester there is exactly one output bit per input bit. With Manchester on there are two output half-bits per input bit, on consecutive cycles.

Top module: `line_coder`

## Requirements
- R1: After reset, txo_stb, rxo_stb and rxo_err are all low.
- R2: The output strobe timing depends on Manchester.
  - With cfg_manch=0, each tx_stb gives exactly one txo_stb, in the next cycle.
  - With cfg_manch=1, each tx_stb gives txo_stb in each of the two following cycles. tx_stb must then be at least two cycles apart.
  - No txo_stb occurs otherwise.
- R3: With cfg_manch=1, the coded bit is sent as two half-bits, first half first. Coded 0 is sent as 0 then 1, and coded 1 as 1 then 0 (before inversion).
- R4: With cfg_diff=1, the transmitted level changes for a 1 and holds for a 0. The level is 0 at packet start, so a leading 1 is sent as 1.
- R5: Inversion acts on each output bit after Manchester coding.
  - With cfg_four_level=0, cfg_inv_a inverts every output bit and cfg_inv_b has no effect.
  - With cfg_four_level=1, output bits alternate between the MSB and the LSB of a dibit, starting with the MSB after pkt_start. cfg_inv_a inverts MSBs and cfg_inv_b inverts LSBs.
  - Receive inversion follows the same rule, counted on rx_stb.
- R6: Additive whitening is selected by cfg_wmode=1. cfg_poly selects the polynomial: 0 or 3 gives x^9+x^5+1, 1 gives x^15+x^14+1, 2 gives x^17+x^12+1. For each bit:
  - the key is k = r[D-1] xor r[T-1], where D is the degree and T the middle exponent;
  - the output is the data bit xor k;
  - r shifts left with k entering bit 0.
  - r is all ones at packet start.
- R7: Multiplicative whitening is selected by cfg_wmode=2. It uses the same key and polynomials as R6, but the transmitted bit, not the key, enters bit 0. r is again all ones at packet start.
- R8: With cfg_wmode of 0 or 3, data passes through the whitener unchanged whatever cfg_poly is. Whitening never changes the number of output strobes.
- R9: For every configuration, when txo_bit and txo_stb are looped into rx_bit and rx_stb under a common pkt_start, the receive path returns each transmitted data bit in order. rxo_stb follows one cycle after the rx_stb that completes the bit.
- R10: With cfg_manch=1, a received half-bit pair of 00 or 11 raises rxo_err together with rxo_stb, and rxo_bit then gives the first half. rxo_err is never raised with cfg_manch=0.
- R11: In multiplicative mode the receive descrambler shifts in the received bits. After D received bits its output is correct, whatever state the transmitter started from.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_four_level | input | 1 | Dibit mode for inversion |
| cfg_inv_a | input | 1 | Invert all bits, or dibit MSB in four-level mode |
| cfg_inv_b | input | 1 | Invert dibit LSB in four-level mode |
| cfg_diff | input | 1 | Differential coding enable |
| cfg_manch | input | 1 | Manchester coding enable |
| cfg_wmode | input | 2 | Whitening: 0/3 off, 1 additive, 2 multiplicative |
| cfg_poly | input | 2 | Polynomial select: 0/3 degree 9, 1 degree 15, 2 degree 17 |
| pkt_start | input | 1 | Restart all coding state at the start of a packet |
| tx_bit | input | 1 | Transmit data bit |
| tx_stb | input | 1 | Transmit bit strobe |
| txo_bit | output | 1 | Coded transmit bit or half-bit |
| txo_stb | output | 1 | Coded transmit strobe |
| rx_bit | input | 1 | Received coded bit or half-bit |
| rx_stb | input | 1 | Received coded strobe |
| rxo_bit | output | 1 | Decoded receive data bit |
| rxo_stb | output | 1 | Decoded receive strobe |
| rxo_err | output | 1 | Manchester pair error |

## Verification
Some faults show at once at txo_bit, in the first few bits after pkt_start:
- a whitener tap or seed fault;
- a differential level that does not clear at packet start;
- a dibit phase that does not clear at packet start.

A fault in the receive register shows as a mismatch at rxo_bit in the looped-back bit that follows it. Multiplicative mode is the exception: a wrong descrambler state heals after D bits. For that reason the self-synchronising check only compares bits past that window. A missed or extra half-bit strobe shows as a wrong strobe count, and with Manchester it shows as spurious rxo_err pulses within one packet.

// File: rtl/lc_pkg.sv
package lc_pkg;
   typedef enum logic [1:0] {
      WH_OFF = 2'd0,
      WH_ADD = 2'd1,
      WH_MUL = 2'd2,
      WH_RSV = 2'd3
   } wh_mode_e;

   localparam int NUM_POLY = 3;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/lc_scrambler.sv
module lc_scrambler
   import lc_pkg::*;
#(
   parameter bit DESCR = 1'b0,
   parameter int DEG0  = 9,
   parameter int TAP0  = 5,
   parameter int DEG1  = 15,
   parameter int TAP1  = 14,
   parameter int DEG2  = 17,
   parameter int TAP2  = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       step,
   input  logic [1:0] mode,
   input  logic [1:0] poly,
   input  logic       din,
   output logic       dout
);
   localparam int W = max3(DEG0, DEG1, DEG2);

   if (TAP0 >= DEG0 || TAP1 >= DEG1 || TAP2 >= DEG2 || TAP0 < 1 || TAP1 < 1 || TAP2 < 1) begin : g_bad_tap
      $error("lc_scrambler: each tap must lie between 1 and its degree minus one");
   end
   if (W < 2) begin : g_bad_deg
      $error("lc_scrambler: degree must be at least 2");
   end

   logic [W-1:0]        sr_q;
   logic [W-1:0]        sr_cur;
   logic [W-1:0]        sr_nxt;
   logic [NUM_POLY-1:0] fb_vec;
   logic                fb;

   assign sr_cur = restart ? {W{1'b1}} : sr_q;

   for (genvar g = 0; g < NUM_POLY; g++) begin : g_poly
      localparam int D = (g == 0) ? DEG0 : (g == 1) ? DEG1 : DEG2;
      localparam int T = (g == 0) ? TAP0 : (g == 1) ? TAP1 : TAP2;
      assign fb_vec[g] = sr_cur[D-1] ^ sr_cur[T-1];
   end

   always_comb begin
      case (poly)
         2'd1:    fb = fb_vec[1];
         2'd2:    fb = fb_vec[2];
         default: fb = fb_vec[0];
      endcase
   end

   always_comb begin
      dout   = din;
      sr_nxt = sr_cur;
      case (wh_mode_e'(mode))
         WH_ADD: begin
            dout   = din ^ fb;
            sr_nxt = {sr_cur[W-2:0], fb};
         end
         WH_MUL: begin
            dout = din ^ fb;
            if (DESCR) sr_nxt = {sr_cur[W-2:0], din};
            else       sr_nxt = {sr_cur[W-2:0], din ^ fb};
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sr_q <= {W{1'b1}};
      else if (step)    sr_q <= sr_nxt;
      else if (restart) sr_q <= sr_cur;
   end
endmodule

// File: rtl/lc_diff.sv
module lc_diff #(
   parameter bit DECODE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic step,
   input  logic en,
   input  logic din,
   output logic dout
);
   logic lvl_q;
   logic lvl_cur;
   logic lvl_nxt;

   assign lvl_cur = restart ? 1'b0 : lvl_q;
   assign dout    = en ? (din ^ lvl_cur) : din;

   if (DECODE) begin : g_dec
      assign lvl_nxt = din;
   end else begin : g_enc
      assign lvl_nxt = din ^ lvl_cur;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           lvl_q <= 1'b0;
      else if (step && en)  lvl_q <= lvl_nxt;
      else if (restart)     lvl_q <= 1'b0;
   end
endmodule

// File: rtl/lc_invert.sv
module lc_invert (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic step,
   input  logic four_level,
   input  logic inv_a,
   input  logic inv_b,
   input  logic din,
   output logic dout
);
   logic ph_q;
   logic ph_cur;
   logic flip;

   assign ph_cur = restart ? 1'b0 : ph_q;
   assign flip   = (four_level && ph_cur) ? inv_b : inv_a;
   assign dout   = din ^ flip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ph_q <= 1'b0;
      else if (step)    ph_q <= four_level ? ~ph_cur : 1'b0;
      else if (restart) ph_q <= 1'b0;
   end
endmodule

// File: rtl/line_coder.sv
module line_coder #(
   parameter int DEG0 = 9,
   parameter int TAP0 = 5,
   parameter int DEG1 = 15,
   parameter int TAP1 = 14,
   parameter int DEG2 = 17,
   parameter int TAP2 = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_four_level,
   input  logic       cfg_inv_a,
   input  logic       cfg_inv_b,
   input  logic       cfg_diff,
   input  logic       cfg_manch,
   input  logic [1:0] cfg_wmode,
   input  logic [1:0] cfg_poly,
   input  logic       pkt_start,
   input  logic       tx_bit,
   input  logic       tx_stb,
   output logic       txo_bit,
   output logic       txo_stb,
   input  logic       rx_bit,
   input  logic       rx_stb,
   output logic       rxo_bit,
   output logic       rxo_stb,
   output logic       rxo_err
);
   // ---------------- transmit path ----------------
   logic tx_wht;
   logic tx_cod;
   logic pend_q;
   logic pend_bit_q;
   logic emit;
   logic emit_bit;
   logic emit_inv;

   lc_scrambler #(
      .DESCR(1'b0), .DEG0(DEG0), .TAP0(TAP0), .DEG1(DEG1), .TAP1(TAP1), .DEG2(DEG2), .TAP2(TAP2)
   ) u_tx_scr (
      .clk(clk), .rst_n(rst_n), .restart(pkt_start), .step(tx_stb),
      .mode(cfg_wmode), .poly(cfg_poly), .din(tx_bit), .dout(tx_wht)
   );

   lc_diff #(.DECODE(1'b0)) u_tx_diff (
      .clk(clk), .rst_n(rst_n), .restart(pkt_start), .step(tx_stb),
      .en(cfg_diff), .din(tx_wht), .dout(tx_cod)
   );

   assign emit     = tx_stb | pend_q;
   assign emit_bit = tx_stb ? tx_cod : pend_bit_q;

   lc_invert u_tx_inv (
      .clk(clk), .rst_n(rst_n), .restart(pkt_start), .step(emit),
      .four_level(cfg_four_level), .inv_a(cfg_inv_a), .inv_b(cfg_inv_b),
      .din(emit_bit), .dout(emit_inv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txo_bit    <= 1'b0;
         txo_stb    <= 1'b0;
         pend_q     <= 1'b0;
         pend_bit_q <= 1'b0;
      end else begin
         txo_stb    <= emit;
         if (emit) txo_bit <= emit_inv;
         pend_q     <= tx_stb & cfg_manch;
         if (tx_stb) pend_bit_q <= ~tx_cod;
      end
   end

   // ---------------- receive path ----------------
   logic rx_pos;
   logic half_q;
   logic half_cur;
   logic h0_q;
   logic bit_vld;
   logic bit_val;
   logic bit_err;
   logic rx_dd;
   logic rx_dat;

   lc_invert u_rx_inv (
      .clk(clk), .rst_n(rst_n), .restart(pkt_start), .step(rx_stb),
      .four_level(cfg_four_level), .inv_a(cfg_inv_a), .inv_b(cfg_inv_b),
      .din(rx_bit), .dout(rx_pos)
   );

   assign half_cur = pkt_start ? 1'b0 : half_q;
   assign bit_vld  = rx_stb & (~cfg_manch | half_cur);
   assign bit_val  = cfg_manch ? h0_q : rx_pos;
   assign bit_err  = cfg_manch & (h0_q == rx_pos);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= 1'b0;
         h0_q   <= 1'b0;
      end else if (rx_stb && cfg_manch) begin
         half_q <= ~half_cur;
         if (!half_cur) h0_q <= rx_pos;
      end else if (pkt_start || !cfg_manch) begin
         half_q <= 1'b0;
      end
   end

   lc_diff #(.DECODE(1'b1)) u_rx_diff (
      .clk(clk), .rst_n(rst_n), .restart(pkt_start), .step(bit_vld),
      .en(cfg_diff), .din(bit_val), .dout(rx_dd)
   );

   lc_scrambler #(
      .DESCR(1'b1), .DEG0(DEG0), .TAP0(TAP0), .DEG1(DEG1), .TAP1(TAP1), .DEG2(DEG2), .TAP2(TAP2)
   ) u_rx_scr (
      .clk(clk), .rst_n(rst_n), .restart(pkt_start), .step(bit_vld),
      .mode(cfg_wmode), .poly(cfg_poly), .din(rx_dd), .dout(rx_dat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxo_bit <= 1'b0;
         rxo_stb <= 1'b0;
         rxo_err <= 1'b0;
      end else begin
         rxo_stb <= bit_vld;
         rxo_err <= bit_vld & bit_err;
         if (bit_vld) rxo_bit <= rx_dat;
      end
   end
endmodule

// File: rtl/line_coder_chk.sv
module line_coder_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_four_level,
   input logic cfg_manch,
   input logic tx_stb,
   input logic txo_bit,
   input logic txo_stb,
   input logic rx_stb,
   input logic rxo_stb,
   input logic rxo_err
);
   // R2: one strobe, one cycle later, without Manchester
   p_plain_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_stb && !cfg_manch |=> txo_stb);

   // R2: no coded strobe without a source strobe one or two cycles back
   p_strobe_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      txo_stb |-> ($past(tx_stb) || ($past(tx_stb, 2) && $past(cfg_manch, 2))));

   // R3: two complementary half-bits in two-level mode
   p_manch_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_stb && cfg_manch && !cfg_four_level |=> txo_stb ##1 (txo_stb && (txo_bit != $past(txo_bit))));

   // R9: decoded strobe only after a received strobe
   p_rx_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rxo_stb |-> $past(rx_stb));

   // R10: error flag rides on a decoded strobe
   p_err_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rxo_err |-> rxo_stb);

   // R10: no error flag without Manchester
   p_err_manch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rxo_err |-> $past(cfg_manch));
endmodule

bind line_coder line_coder_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_four_level(cfg_four_level), .cfg_manch(cfg_manch),
   .tx_stb(tx_stb), .txo_bit(txo_bit), .txo_stb(txo_stb),
   .rx_stb(rx_stb), .rxo_stb(rxo_stb), .rxo_err(rxo_err)
);

// File: tb/line_coder_tb_top.sv
module line_coder_tb_top;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       cfg_four_level = 1'b0, cfg_inv_a = 1'b0, cfg_inv_b = 1'b0;
   logic       cfg_diff = 1'b0, cfg_manch = 1'b0;
   logic [1:0] cfg_wmode = 2'd0, cfg_poly = 2'd0;
   logic       pkt_start = 1'b0, tx_bit = 1'b0, tx_stb = 1'b0;
   logic       txo_bit, txo_stb;
   logic       rx_sel = 1'b0, drv_rx_bit = 1'b0, drv_rx_stb = 1'b0;
   logic       rx_bit, rx_stb;
   logic       rxo_bit, rxo_stb, rxo_err;

   assign rx_bit = rx_sel ? drv_rx_bit : txo_bit;
   assign rx_stb = rx_sel ? drv_rx_stb : txo_stb;

   line_coder dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_four_level(cfg_four_level), .cfg_inv_a(cfg_inv_a),
      .cfg_inv_b(cfg_inv_b), .cfg_diff(cfg_diff), .cfg_manch(cfg_manch), .cfg_wmode(cfg_wmode),
      .cfg_poly(cfg_poly), .pkt_start(pkt_start), .tx_bit(tx_bit), .tx_stb(tx_stb),
      .txo_bit(txo_bit), .txo_stb(txo_stb), .rx_bit(rx_bit), .rx_stb(rx_stb),
      .rxo_bit(rxo_bit), .rxo_stb(rxo_stb), .rxo_err(rxo_err)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // output monitor
   int rx_cnt = 0;
   int tx_cnt = 0;
   bit rx_got  [64];
   bit rx_egot [64];
   always @(negedge clk) begin
      if (rxo_stb) begin
         rx_got[rx_cnt % 64]  = rxo_bit;
         rx_egot[rx_cnt % 64] = rxo_err;
         rx_cnt++;
      end
      if (txo_stb) tx_cnt++;
   end

   // reference model state
   bit [16:0] m_r;
   bit        m_lvl;
   bit        m_ph;
   bit [31:0] lcg = 32'h1234_5678;

   function automatic int pdeg(input int p);
      return (p == 1) ? 15 : (p == 2) ? 17 : 9;
   endfunction
   function automatic int ptap(input int p);
      return (p == 1) ? 14 : (p == 2) ? 12 : 5;
   endfunction

   task automatic model_tx(input bit b, input int wm, input int pl, input bit df, output bit d);
      bit k, w;
      k = m_r[pdeg(pl)-1] ^ m_r[ptap(pl)-1];
      w = b;
      if (wm == 1) begin w = b ^ k; m_r = {m_r[15:0], k}; end
      else if (wm == 2) begin w = b ^ k; m_r = {m_r[15:0], w}; end
      if (df) begin d = m_lvl ^ w; m_lvl = d; end
      else d = w;
   endtask

   task automatic model_inv(input bit x, input bit fl, input bit ia, input bit ib, output bit y);
      y    = x ^ ((fl && m_ph) ? ib : ia);
      m_ph = fl ? ~m_ph : 1'b0;
   endtask

   task automatic next_rand(output bit b);
      lcg = lcg * 32'd1103515245 + 32'd12345;
      b   = lcg[16];
   endtask

   task automatic run_packet(input int n, input int wm, input int pl, input bit df, input bit mc,
                             input bit fl, input bit ia, input bit ib);
      string tag;
      bit    sent [64];
      bit    b, d, e0, e1;
      int    rx_base, tx_base;
      tag = (wm == 1) ? "R6" : (wm == 2) ? "R7" : mc ? "R3" : df ? "R4" : (ia | ib) ? "R5" : "R8";
      m_r = '1; m_lvl = 1'b0; m_ph = 1'b0;
      rx_base = rx_cnt; tx_base = tx_cnt;
      for (int i = 0; i < n; i++) begin
         next_rand(b);
         sent[i] = b;
         model_tx(b, wm, pl, df, d);
         model_inv(d, fl, ia, ib, e0);
         if (mc) model_inv(~d, fl, ia, ib, e1);
         @(negedge clk);
         tx_bit = b; tx_stb = 1'b1; pkt_start = (i == 0);
         @(negedge clk);
         tx_stb = 1'b0; pkt_start = 1'b0;
         chk(txo_stb == 1'b1, "R2", int'(txo_stb), 1);
         chk(txo_bit == e0, tag, int'(txo_bit), int'(e0));
         if (mc) begin
            @(negedge clk);
            chk(txo_stb == 1'b1, "R2", int'(txo_stb), 1);
            chk(txo_bit == e1, "R3", int'(txo_bit), int'(e1));
         end
         @(negedge clk);
         chk(txo_stb == 1'b0, "R2", int'(txo_stb), 0);
      end
      @(negedge clk);
      @(negedge clk);
      chk(tx_cnt - tx_base == (mc ? 2 * n : n), "R8", tx_cnt - tx_base, mc ? 2 * n : n);
      chk(rx_cnt - rx_base == n, "R9", rx_cnt - rx_base, n);
      for (int i = 0; i < n; i++) begin
         chk(rx_got[(rx_base + i) % 64] == sent[i], "R9", int'(rx_got[(rx_base + i) % 64]), int'(sent[i]));
         chk(rx_egot[(rx_base + i) % 64] == 1'b0, "R10", int'(rx_egot[(rx_base + i) % 64]), 0);
      end
   endtask

   task automatic rx_drive(input bit v);
      @(negedge clk);
      drv_rx_bit = v; drv_rx_stb = 1'b1;
      @(negedge clk);
      drv_rx_stb = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      pkt_start = 1'b1;
      @(negedge clk);
      pkt_start = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(txo_stb == 1'b0, "R1", int'(txo_stb), 0);
      chk(rxo_stb == 1'b0, "R1", int'(rxo_stb), 0);
      chk(rxo_err == 1'b0, "R1", int'(rxo_err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(txo_stb == 1'b0 && rxo_stb == 1'b0, "R1", int'(txo_stb | rxo_stb), 0);

      // sweep all configurations, looped back
      for (int wm = 0; wm < 4; wm++)
         for (int pl = 0; pl < 4; pl++) begin
            if ((wm == 3 || pl == 3) && !(wm == 3 && pl == 3)) continue;
            for (int df = 0; df < 2; df++)
               for (int mc = 0; mc < 2; mc++)
                  for (int fl = 0; fl < 2; fl++)
                     for (int ia = 0; ia < 2; ia++)
                        for (int ib = 0; ib < 2; ib++) begin
                           @(negedge clk);
                           cfg_wmode = 2'(wm); cfg_poly = 2'(pl); cfg_diff = df[0];
                           cfg_manch = mc[0]; cfg_four_level = fl[0];
                           cfg_inv_a = ia[0]; cfg_inv_b = ib[0];
                           run_packet(24, (wm == 3) ? 0 : wm, pl, df[0], mc[0], fl[0], ia[0], ib[0]);
                        end
         end

      // R10: Manchester pair errors, direct receive drive
      @(negedge clk);
      rx_sel = 1'b1;
      cfg_wmode = 2'd0; cfg_diff = 1'b0; cfg_manch = 1'b1;
      cfg_four_level = 1'b0; cfg_inv_a = 1'b0; cfg_inv_b = 1'b0;
      pulse_start();
      begin
         bit pa [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
         bit pb [4] = '{1'b0, 1'b1, 1'b1, 1'b0};
         bit ee [4] = '{1'b1, 1'b1, 1'b0, 1'b0};
         for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            drv_rx_bit = pa[k]; drv_rx_stb = 1'b1;
            @(negedge clk);
            drv_rx_bit = pb[k];
            @(negedge clk);
            drv_rx_stb = 1'b0;
            chk(rxo_stb == 1'b1, "R10", int'(rxo_stb), 1);
            chk(rxo_err == ee[k], "R10", int'(rxo_err), int'(ee[k]));
            chk(rxo_bit == pa[k], "R10", int'(rxo_bit), int'(pa[k]));
         end
      end

      // R11: descrambler self-synchronises from a foreign transmitter state
      cfg_manch = 1'b0;
      for (int pl = 0; pl < 3; pl++) begin
         bit data [40];
         bit b, d;
         int base;
         @(negedge clk);
         cfg_wmode = 2'd2; cfg_poly = 2'(pl);
         pulse_start();
         m_r = 17'h05A3C ^ 17'(pl * 977); m_lvl = 1'b0;
         base = rx_cnt;
         for (int i = 0; i < 40; i++) begin
            next_rand(b);
            data[i] = b;
            model_tx(b, 2, pl, 1'b0, d);
            rx_drive(d);
         end
         @(negedge clk);
         chk(rx_cnt - base == 40, "R11", rx_cnt - base, 40);
         for (int i = pdeg(pl); i < 40; i++)
            chk(rx_got[(base + i) % 64] == data[i], "R11", int'(rx_got[(base + i) % 64]), int'(data[i]));
      end

      finish_run();
   end
endmodule